// File: doc/BRIEF.md
# Supervisory Reset Controller

This block drives the processor's active-low reset line. The line is open-drain and is shared with a push-button, so it is both an output and an input. The block holds reset for as long as a synchronized low-supply indication is present. It also starts a reset when the line is held low from outside for long enough, or when the watchdog reports a fault while its enable is set. After every cause ends, reset stays asserted for a fixed stretch time.

The block records why a reset happened in two sticky flags. One flag covers supply and manual resets, the other covers watchdog faults. Hardware only sets the flags, and the host clears them through a small register write port. The same port holds the trip-point select bit for the analog supply detector.

While reset is asserted the block raises a lockout for the serial interface. A memory operation that is already running when reset begins may finish first. When reset is released, the block gives the watchdog a one-cycle pulse so that it can restart.

Top module: `rst_supervisor`

## Requirements
- R1: While `lowsup_i` is high, `rst_drv_o` is 1 from the next cycle on. After `lowsup_i` falls, `rst_drv_o` stays 1 for S = 100*CYC_PER_MS cycles, counted from the last cycle in which `lowsup_i` was sampled high, and then goes to 0.
- R2: When `pin_i` goes low from outside, `pin_i` passes through a two-flop synchronizer. If the synchronized level stays low for D = CYC_PER_MS consecutive samples, `rst_drv_o` rises D+2 cycles after the pin fell. It then stays 1 for S cycles.
- R3: An external low pulse on `pin_i` that lasts fewer than D cycles causes no reset.
- R4: Samples of `pin_i` taken while `rst_drv_o` is 1, and in the two cycles after it falls, are ignored. As a result, a block-driven reset never retriggers itself and ends after exactly S cycles.
- R5: A one-cycle `wdt_fault_i` with `wdt_en_i`=1 sets `rst_drv_o` to 1 in the next cycle, for S cycles. With `wdt_en_i`=0 the fault drives no reset.
- R6: Flags after reset: `flag_por_o`=1, `flag_wdt_o`=0. A low-supply or manual reset cause sets `flag_por_o`. Any watchdog fault sets `flag_wdt_o`, whatever the state of `wdt_en_i`. Both flags stay set until the host clears them.
- R7: A write to address 4'h9 clears `flag_wdt_o` when data bit 7 is 0 and clears `flag_por_o` when data bit 6 is 0. A data bit of 1 leaves its flag unchanged. A hardware set in the same cycle wins over a clear. Writes to any other address leave the flags unchanged.
- R8: A write to address 4'hB loads data bit 0 into `trip_sel_o` (0 selects the lower threshold, 1 the higher). All other data bits are ignored. The reset value is 0.
- R9: `lockout_o` is 0 whenever `rst_drv_o` is 0. It is 1 whenever `rst_drv_o` is 1, except while a memory operation that was busy when reset began still holds `mem_busy_i` high. Once `mem_busy_i` drops during a reset, the lockout holds until release.
- R10: `rel_pulse_o` is 1 for exactly the one cycle in which `rst_drv_o` has just gone from 1 to 0.
- R11: After the block's own reset, `rst_drv_o` and `lockout_o` are 1, and `rst_drv_o` is released after S cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| lowsup_i | input | 1 | Synchronized low-supply indication, active high |
| pin_i | input | 1 | Level sensed on the shared reset line (0 = low) |
| wdt_fault_i | input | 1 | One-cycle watchdog timeout pulse |
| wdt_en_i | input | 1 | Watchdog enable; allows a fault to drive reset |
| mem_busy_i | input | 1 | A memory operation is in progress |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 4 | Host register address |
| reg_wdata_i | input | 8 | Host register write data |
| rst_drv_o | output | 1 | 1 = pull the reset line low |
| lockout_o | output | 1 | Serial bus lockout |
| rel_pulse_o | output | 1 | One-cycle pulse on reset release |
| flag_por_o | output | 1 | Sticky supply/manual reset flag |
| flag_wdt_o | output | 1 | Sticky watchdog reset flag |
| trip_sel_o | output | 1 | Supply trip point select for the detector |

## Verification
The bench builds the block with CYC_PER_MS=4. This makes the stretch window 400 cycles and the debounce window 4 cycles. With these values every stretch length can be counted exactly, and a 3-cycle glitch falls one sample short of the debounce window. The bench models the shared line as a wired-AND of the switch and the block's own drive. This lets the self-retrigger and blanking cases arise the way they would on a board.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam logic [3:0] FLAG_ADDR = 4'h9;
  localparam logic [3:0] TRIP_ADDR = 4'hB;
  localparam int WDT_FLAG_BIT = 7;
  localparam int POR_FLAG_BIT = 6;
  localparam int TRIP_BIT     = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_RUN} stretch_st_t;

  function automatic int ms_cycles(input int cyc_per_ms, input int ms);
    return cyc_per_ms * ms;
  endfunction
endpackage

// File: rtl/rsv_pin_filter.sv
module rsv_pin_filter #(
  parameter int DEB_CYC   = 1000,
  parameter int BLANK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic drive_i,
  output logic blanked_o,
  output logic evt_o
);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic          sync1_q, sync2_q;
  logic [DW-1:0] deb_q;
  logic [BW-1:0] blank_q;
  logic          low_seen;

  assign blanked_o = drive_i || (blank_q != '0);
  assign low_seen  = !blanked_o && !sync2_q;
  assign evt_o     = low_seen && (deb_q == DW'(DEB_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      deb_q   <= '0;
      blank_q <= BW'(BLANK_CYC);
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (drive_i)
        blank_q <= BW'(BLANK_CYC);
      else if (blank_q != '0)
        blank_q <= blank_q - 1'b1;
      if (!low_seen)
        deb_q <= '0;
      else if (deb_q != DW'(DEB_CYC))
        deb_q <= deb_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch
  import rsv_pkg::*;
#(
  parameter int STRETCH_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic trig_i,
  output logic drive_o,
  output logic rel_o
);
  localparam int CW = $clog2(STRETCH_CYC + 1);

  stretch_st_t   st_q;
  logic [CW-1:0] cnt_q;
  logic          prev_q;

  assign drive_o = (st_q != ST_IDLE);
  assign rel_o   = prev_q && !drive_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      prev_q <= drive_o;
      if (hold_i) begin
        st_q  <= ST_HOLD;
        cnt_q <= '0;
      end else if (trig_i) begin
        st_q  <= ST_RUN;
        cnt_q <= '0;
      end else begin
        case (st_q)
          ST_HOLD, ST_RUN: begin
            if (cnt_q == CW'(STRETCH_CYC - 1)) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end else begin
              st_q  <= ST_RUN;
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rsv_flags.sv
module rsv_flags
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_por_i,
  input  logic       set_wdt_i,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       por_o,
  output logic       wdt_o,
  output logic       trip_o
);
  logic flag_wr, trip_wr;
  logic keep_por, keep_wdt;

  assign flag_wr  = we_i && (addr_i == FLAG_ADDR);
  assign trip_wr  = we_i && (addr_i == TRIP_ADDR);
  assign keep_por = !flag_wr || wdata_i[POR_FLAG_BIT];
  assign keep_wdt = !flag_wr || wdata_i[WDT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_o  <= 1'b1;
      wdt_o  <= 1'b0;
      trip_o <= 1'b0;
    end else begin
      por_o <= set_por_i || (por_o && keep_por);
      wdt_o <= set_wdt_i || (wdt_o && keep_wdt);
      if (trip_wr)
        trip_o <= wdata_i[TRIP_BIT];
    end
  end

  logic unused_data;
  assign unused_data = ^wdata_i[5:1];
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int CYC_PER_MS  = 1000,
  parameter int STRETCH_MS  = 100,
  parameter int DEBOUNCE_MS = 1,
  parameter int BLANK_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lowsup_i,
  input  logic       pin_i,
  input  logic       wdt_fault_i,
  input  logic       wdt_en_i,
  input  logic       mem_busy_i,
  input  logic       reg_we_i,
  input  logic [3:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic       rst_drv_o,
  output logic       lockout_o,
  output logic       rel_pulse_o,
  output logic       flag_por_o,
  output logic       flag_wdt_o,
  output logic       trip_sel_o
);
  localparam int STRETCH_CYC = ms_cycles(CYC_PER_MS, STRETCH_MS);
  localparam int DEB_CYC     = ms_cycles(CYC_PER_MS, DEBOUNCE_MS);

  logic manual_evt;
  logic pin_blanked;
  logic wdt_trig;
  logic any_trig;
  logic grace_q;

  assign wdt_trig = wdt_fault_i && wdt_en_i;
  assign any_trig = manual_evt || wdt_trig;

  rsv_pin_filter #(.DEB_CYC(DEB_CYC), .BLANK_CYC(BLANK_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .drive_i(rst_drv_o),
    .blanked_o(pin_blanked), .evt_o(manual_evt)
  );

  rsv_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk(clk), .rst_n(rst_n), .hold_i(lowsup_i), .trig_i(any_trig),
    .drive_o(rst_drv_o), .rel_o(rel_pulse_o)
  );

  rsv_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_por_i(lowsup_i || manual_evt), .set_wdt_i(wdt_fault_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .por_o(flag_por_o), .wdt_o(flag_wdt_o), .trip_o(trip_sel_o)
  );

  // An operation busy at reset onset keeps its grace until it completes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      grace_q <= 1'b0;
    else if (!rst_drv_o)
      grace_q <= 1'b1;
    else
      grace_q <= grace_q && mem_busy_i;
  end

  assign lockout_o = rst_drv_o && !(grace_q && mem_busy_i);
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int STRETCH_CYC = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic lowsup_i,
  input logic wdt_fault_i,
  input logic wdt_en_i,
  input logic mem_busy_i,
  input logic manual_evt,
  input logic rst_drv_o,
  input logic lockout_o,
  input logic rel_pulse_o,
  input logic flag_por_o,
  input logic flag_wdt_o
);
  localparam int QW = $clog2(STRETCH_CYC + 2);
  logic [QW-1:0] quiet_q;
  logic          cause;

  assign cause = lowsup_i || manual_evt || (wdt_fault_i && wdt_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_q <= '0;
    else if (cause)
      quiet_q <= '0;
    else if (quiet_q != QW'(STRETCH_CYC + 1))
      quiet_q <= quiet_q + 1'b1;
  end

  AST_LOWSUP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    lowsup_i |=> rst_drv_o); // R1
  AST_RELEASE_AFTER_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_drv_o) |-> (quiet_q == QW'(STRETCH_CYC))); // R4
  AST_NO_EVT_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_drv_o |-> !manual_evt); // R4
  AST_WDT_ENABLED_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_fault_i && wdt_en_i) |=> rst_drv_o); // R5
  AST_WDT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_fault_i |=> flag_wdt_o); // R6
  AST_POR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lowsup_i || manual_evt) |=> flag_por_o); // R6
  AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_drv_o |-> !lockout_o); // R9
  AST_LOCK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_drv_o && !mem_busy_i) |-> lockout_o); // R9
  AST_REL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse_o |-> (!rst_drv_o && $past(rst_drv_o))); // R10
endmodule

bind rst_supervisor rsv_checker #(.STRETCH_CYC(STRETCH_CYC)) u_rsv_checker (
  .clk(clk), .rst_n(rst_n), .lowsup_i(lowsup_i), .wdt_fault_i(wdt_fault_i),
  .wdt_en_i(wdt_en_i), .mem_busy_i(mem_busy_i), .manual_evt(manual_evt),
  .rst_drv_o(rst_drv_o), .lockout_o(lockout_o), .rel_pulse_o(rel_pulse_o),
  .flag_por_o(flag_por_o), .flag_wdt_o(flag_wdt_o)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int CPM = 4;
  localparam int S   = 100 * CPM;
  localparam int D   = CPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lowsup = 1'b0, wdt_fault = 1'b0, wdt_en = 1'b0, mem_busy = 1'b0;
  logic sw_n = 1'b1, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rst_drv, lockout, rel_pulse, fpor, fwdt, trip;
  logic pin_w;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign pin_w = sw_n && !rst_drv;

  rst_supervisor #(.CYC_PER_MS(CPM)) i_rst_supervisor (
    .clk(clk), .rst_n(rst_n), .lowsup_i(lowsup), .pin_i(pin_w),
    .wdt_fault_i(wdt_fault), .wdt_en_i(wdt_en), .mem_busy_i(mem_busy),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .rst_drv_o(rst_drv), .lockout_o(lockout), .rel_pulse_o(rel_pulse),
    .flag_por_o(fpor), .flag_wdt_o(fwdt), .trip_sel_o(trip)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (rst_drv && n < 10 * S) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    check("R11 drive at reset", rst_drv, 1);
    check("R11 lockout at reset", lockout, 1);
    check("R6 por flag at reset", fpor, 1);
    check("R6 wdt flag at reset", fwdt, 0);
    check("R8 trip at reset", trip, 0);
    rst_n = 1'b1;
    wait_release(n);
    check("R11 release length", n, S);
    check("R10 release pulse", rel_pulse, 1);
    check("R9 lockout idle", lockout, 0);
    @(negedge clk);
    check("R10 pulse one cycle", rel_pulse, 0);
  endtask

  task automatic t_flag_clear();
    reg_write(4'h8, 8'h00);
    check("R7 other address no effect", fpor, 1);
    reg_write(4'h9, 8'h40);
    check("R7 bit6 one keeps por", fpor, 1);
    reg_write(4'h9, 8'h80);
    check("R7 bit6 zero clears por", fpor, 0);
  endtask

  task automatic t_lowsup();
    int n;
    lowsup = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 drive during low supply", rst_drv, 1);
    check("R9 lockout during low supply", lockout, 1);
    check("R6 por flag by low supply", fpor, 1);
    lowsup = 1'b0;
    wait_release(n);
    check("R1 stretch after low supply", n, S);
    reg_write(4'h9, 8'h00);
  endtask

  task automatic t_manual();
    int n, m;
    sw_n = 1'b0;
    n = 0;
    while (!rst_drv && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R2 manual detect latency", n, D + 2);
    check("R6 por flag by manual", fpor, 1);
    sw_n = 1'b1;
    wait_release(m);
    check("R2 R4 manual stretch length", m, S);
    repeat (20) @(negedge clk);
    check("R4 no self retrigger", rst_drv, 0);
    reg_write(4'h9, 8'h00);
  endtask

  task automatic t_glitch();
    sw_n = 1'b0;
    repeat (D - 1) @(negedge clk);
    sw_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R3 short glitch ignored", rst_drv, 0);
    check("R3 glitch sets no flag", fpor, 0);
  endtask

  task automatic t_wdt_disabled();
    wdt_en = 1'b0; wdt_fault = 1'b1;
    @(negedge clk);
    wdt_fault = 1'b0;
    check("R6 wdt flag with enable clear", fwdt, 1);
    repeat (3) @(negedge clk);
    check("R5 no drive with enable clear", rst_drv, 0);
    wdt_fault = 1'b1; we = 1'b1; addr = 4'h9; wdata = 8'h00;
    @(negedge clk);
    wdt_fault = 1'b0; we = 1'b0;
    check("R7 set wins over clear", fwdt, 1);
    reg_write(4'h9, 8'h40);
    check("R7 bit7 zero clears wdt", fwdt, 0);
  endtask

  task automatic t_wdt_lockout();
    int n;
    mem_busy = 1'b1;
    wdt_en = 1'b1; wdt_fault = 1'b1;
    @(negedge clk);
    wdt_fault = 1'b0;
    check("R5 drive after enabled fault", rst_drv, 1);
    check("R9 busy operation not locked", lockout, 0);
    mem_busy = 1'b0;
    @(negedge clk);
    check("R9 lockout after busy ends", lockout, 1);
    mem_busy = 1'b1;
    @(negedge clk);
    check("R9 lockout held on new busy", lockout, 1);
    mem_busy = 1'b0;
    wait_release(n);
    check("R5 watchdog stretch length", n + 2, S);
    check("R9 lockout released", lockout, 0);
    wdt_en = 1'b0;
  endtask

  task automatic t_trip();
    reg_write(4'hB, 8'h01);
    check("R8 trip set", trip, 1);
    reg_write(4'hB, 8'hFE);
    check("R8 only bit0 counts", trip, 0);
    reg_write(4'hA, 8'h01);
    check("R8 other address ignored", trip, 0);
  endtask

  initial begin
    t_reset();
    t_flag_clear();
    t_lowsup();
    t_manual();
    t_glitch();
    t_wdt_disabled();
    t_wdt_lockout();
    t_trip();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule